// File: doc/BRIEF.md
# Consecutive Missed-Acknowledge Trip Detector

This block supervises a handshake in which a slow check strobe asks for an acknowledge level. It runs entirely on the system clock. Both inputs are first brought through a short flip-flop synchroniser. The strobe's rising edge is then found by comparing the synchronised strobe with its value one clock earlier. On each such edge the block takes the synchronised acknowledge. A low value is a missed acknowledge, and a high value breaks the run.

When the number of back-to-back misses reaches the threshold, the block emits a one-clock trip pulse. It then starts counting a new run from zero. The strobe is never used as a clock. Only its rising edge counts as an event, so one strobe pulse is counted exactly once however long it stays high.

Top module: `miss_trip_detector`

## Requirements
- R1: On each rising edge of `check_i`, a low `ok_i` (level 0) adds one to the run of consecutive misses.
- R2: On a rising edge of `check_i`, a high `ok_i` (level 1) clears the run to zero, so misses separated by a good acknowledge do not add up.
- R3: When a miss brings the run to `THRESH` (default 6), `trip_o` is high for exactly one clock. With inputs changed between clock edges, that clock starts at the third rising clock edge after the change: two synchroniser stages plus the output register.
- R4: The clock after a trip, the run is zero again, so another `THRESH` consecutive misses are needed for the next trip.
- R5: Only the low-to-high transition of `check_i` is an event. Holding `check_i` high for many clocks counts once, and its falling edge counts as nothing.
- R6: A synchronous active-high `rst` clears the run and drives `trip_o` low. A `check_i` that is already high while `rst` is asserted and stays high after release is not counted as an event.
- R7: Changes of `ok_i` with no rising edge of `check_i` leave the run unchanged.
- R8: `trip_o` is low on every clock other than the one following a threshold-reaching miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| check_i | input | 1 | Check strobe, asynchronous to clk, slow |
| ok_i | input | 1 | Acknowledge level, low means missed |
| trip_o | output | 1 | One-clock pulse after THRESH consecutive misses |

## Verification
Every 8-bit pattern of acknowledge values is played as eight strobe pulses after a reset. This covers runs that end just short of the threshold, runs that reach it exactly, runs broken by a single good sample at each position, and runs long enough to trip, restart and build again. Separate sequences hold the strobe high for many clocks and toggle the acknowledge while it is high or low. These show whether level, falling edge or acknowledge alone are wrongly counted as events. A reset is applied with the strobe high, and another part way through a run. These tell a proper restart apart from a stale count or a phantom edge at reset release.

// File: rtl/tripdet_pkg.sv
package tripdet_pkg;
  parameter int unsigned DEF_THRESH = 6;
  parameter int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/tripdet_sync.sv
module tripdet_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tripdet_rise.sv
module tripdet_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;

  // prev tracks the level during reset too, so a level held high
  // through reset is not seen as an edge afterwards
  always_ff @(posedge clk) prev <= lvl;

  assign rise = lvl & ~prev & ~rst;
endmodule

// File: rtl/tripdet_run.sv
module tripdet_run #(
  parameter int unsigned THRESH = 6,
  localparam int unsigned CW    = $clog2(THRESH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  logic          ack,
  output logic [CW-1:0] cnt,
  output logic          trip
);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      trip <= 1'b0;
    end else begin
      trip <= 1'b0;
      if (ev) begin
        if (ack) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          cnt  <= '0;
          trip <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/miss_trip_detector.sv
module miss_trip_detector #(
  parameter int unsigned THRESH = tripdet_pkg::DEF_THRESH,
  parameter int unsigned SYNC   = tripdet_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rst,
  input  logic check_i,
  input  logic ok_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(THRESH + 1);

  logic [1:0]    s_q;
  logic          chk_s;
  logic          ok_s;
  logic          chk_rise;
  logic [CW-1:0] run_cnt;

  tripdet_sync #(.STAGES(SYNC), .W(2)) u_sync (
    .clk (clk),
    .d   ({check_i, ok_i}),
    .q   (s_q)
  );

  assign chk_s = s_q[1];
  assign ok_s  = s_q[0];

  tripdet_rise u_rise (
    .clk  (clk),
    .rst  (rst),
    .lvl  (chk_s),
    .rise (chk_rise)
  );

  tripdet_run #(.THRESH(THRESH)) u_run (
    .clk  (clk),
    .rst  (rst),
    .ev   (chk_rise),
    .ack  (ok_s),
    .cnt  (run_cnt),
    .trip (trip_o)
  );
endmodule

// File: rtl/miss_trip_detector_chk.sv
module miss_trip_detector_chk #(
  parameter int unsigned THRESH = 6,
  localparam int unsigned CW    = $clog2(THRESH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          rise,
  input logic          ok_s,
  input logic [CW-1:0] cnt,
  input logic          trip
);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  p_miss_step_r1: assert property (@(posedge clk) disable iff (rst)
    (rise && !ok_s && cnt != LAST) |=> (cnt == CW'($past(cnt) + 1'b1)));

  p_ack_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (rise && ok_s) |=> (cnt == '0));

  p_trip_one_clk_r3: assert property (@(posedge clk) disable iff (rst)
    trip |=> !trip);

  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    trip |-> (cnt == '0));

  p_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(THRESH));

  p_reset_r6: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !trip));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!rise && !trip) |=> ($stable(cnt) && !trip));

  p_trip_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (!(rise && !ok_s && cnt == LAST)) |=> !trip);
endmodule

bind miss_trip_detector miss_trip_detector_chk #(.THRESH(THRESH)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .rise (chk_rise),
  .ok_s (ok_s),
  .cnt  (run_cnt),
  .trip (trip_o)
);

// File: tb/test_miss_trip_detector.sv
module test_miss_trip_detector;
  localparam int THR = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic check_i = 1'b0;
  logic ok_i = 1'b1;
  logic trip_o;

  int n_chk  = 0;
  int n_fail = 0;
  int run    = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  miss_trip_detector #(.THRESH(THR)) i_miss_trip_detector (
    .clk     (clk),
    .rst     (rst),
    .check_i (check_i),
    .ok_i    (ok_i),
    .trip_o  (trip_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: trip_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    run = 0;
  endtask

  // one strobe pulse; hold = clocks check stays high after the trip sample
  task automatic pulse(input logic okv, input int hold);
    logic exp;
    @(negedge clk);
    check_i = 1'b1;
    ok_i    = okv;
    exp = 1'b0;
    if (!okv) begin
      run++;
      if (run == THR) begin
        exp = 1'b1;
        run = 0;
      end
    end else begin
      run = 0;
    end
    repeat (3) @(posedge clk);
    #1 check(trip_o, exp, exp ? "R3" : "R1/R2");
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      ok_i = ~ok_i;
      @(posedge clk);
      #1 check(trip_o, 1'b0, "R5");
    end
    @(negedge clk);
    check_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 check(trip_o, 1'b0, "R8");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: trip_o=%0b expected finish", trip_o);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 check(trip_o, 1'b0, "R6 reset");
    do_reset();

    // R5: long-held strobe counts once; R7: ok toggles while held
    for (int k = 0; k < THR; k++) pulse(1'b0, 9);

    // R7: ok wiggles with check low, then 5 misses must not trip
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ok_i = ~ok_i;
      @(posedge clk);
      #1 check(trip_o, 1'b0, "R7");
    end
    for (int k = 0; k < THR - 1; k++) pulse(1'b0, 0);
    pulse(1'b0, 0);

    // R6: reset mid-run with strobe high through release
    for (int k = 0; k < 3; k++) pulse(1'b0, 0);
    @(negedge clk);
    check_i = 1'b1;
    ok_i    = 1'b0;
    rst     = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    run = 0;
    repeat (6) begin
      @(posedge clk);
      #1 check(trip_o, 1'b0, "R6");
    end
    @(negedge clk);
    check_i = 1'b0;
    repeat (3) @(posedge clk);
    for (int k = 0; k < THR; k++) pulse(1'b0, 0);

    // R1 R2 R3 R4: sweep all 8-pulse acknowledge patterns
    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int b = 0; b < 8; b++) pulse(p[b], 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule